// File: doc/BRIEF.md
# Commit-Record Decoupling Queue with System-Call Barrier

This block sits between a main processor core and a separate tag-checking coprocessor. Each time the core commits an instruction it pushes one record into a bounded FIFO. The record holds the program counter, the instruction (or micro-op) encoding and the physical memory address. The address is already physical, so the coprocessor needs no translation hardware of its own. The coprocessor pops records at its own pace. With each pop it reports whether the popped record raised a security exception.

The block holds the core back in three situations:

- **Queue full.** The core stalls while the queue is full, unless a pop in the same cycle frees a slot.
- **System call.** A system call commits as an ordinary record, after which the core stays stalled until the coprocessor has popped every record up to and including that one.
- **Security exception.** The exception is latched and shown to the core. The core stays stalled and no further records are taken until the core acknowledges.

A three-state controller sets the stall:

- `ST_RUN`: normal streaming. Transitions:
  - `RUN->DRAIN` when a system-call record is accepted.
  - `RUN->EXC` when a pop carries an exception.
- `ST_DRAIN`: system-call barrier. Transitions:
  - `DRAIN->EXC` on an exception pop; this takes priority.
  - `DRAIN->RUN` when the queue is seen empty.
- `ST_EXC`: exception held. Transition:
  - `EXC->RUN` on acknowledge.

Top module: `cop_decouple_q`

## Requirements
- R1: After reset the queue is empty (`pop_valid`=0), and `core_stall` and `core_exc` are 0.
- R2: Accepted records leave in push order, with PC, encoding, physical address and system-call flag unchanged. A push is accepted in a cycle where `push_valid`=1 and `core_stall`=0.
- R3: With DEPTH records held and no pop requested, `core_stall` is 1 and a push is not stored.
- R4: With the queue full, a pop and a push in the same cycle are both taken. `core_stall` is 0 in that cycle and the queue stays full afterwards.
- R5: The system-call record (`push_syscall`=1) is stored. From the next cycle `core_stall` is 1 until the queue has been empty for one cycle, and it drops in the cycle after that.
- R6: A pop with `cop_exc`=1 sets `core_exc` and `core_stall` to 1 from the next cycle.
- R7: While `core_exc` is 1, pushes are not stored. One cycle of `exc_ack` clears `core_exc` and `core_stall` in the cycle after it.
- R8: An exception during a system-call drain keeps `core_stall` at 1 after the queue empties, until it is acknowledged.
- R9: A pop request on an empty queue has no effect: nothing is removed, and its `cop_exc` is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Core offers a committed record |
| push_pc | input | PC_W | Program counter of the record |
| push_enc | input | ENC_W | Instruction or micro-op encoding |
| push_paddr | input | PA_W | Physical address |
| push_syscall | input | 1 | Record is a system call |
| core_stall | output | 1 | Holds back commit in the core |
| core_exc | output | 1 | Security exception latched |
| pop_valid | output | 1 | Head record present |
| pop_pc | output | PC_W | Head program counter |
| pop_enc | output | ENC_W | Head encoding |
| pop_paddr | output | PA_W | Head physical address |
| pop_syscall | output | 1 | Head is a system call |
| cop_pop | input | 1 | Coprocessor consumes the head record |
| cop_exc | input | 1 | Exception result for the record popped this cycle |
| exc_ack | input | 1 | Core acknowledges the exception |

## Verification
The bench builds the block with DEPTH=5 and the default 32/32/36-bit field widths. A depth of five makes the full boundary reachable in a handful of pushes. It also makes the read and write pointers wrap at a value that is not a power of two. The scenarios walk each controller transition: a system-call drain, an exception raised in streaming mode, an exception raised during a drain, and a pop request against an empty queue.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_EXC   = 2'd2
    } cdq_state_e;
endpackage

// File: rtl/cdq_ring.sv
module cdq_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_en,
    input  logic [W-1:0] push_data,
    input  logic         pop_en,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_en) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop_en)
                rd_ptr <= step(rd_ptr);
            unique case ({push_en, pop_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R3: a push into a full ring only happens alongside a pop
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_en) |-> pop_en);
    // R9: never pop an empty ring
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty);
    // R4: simultaneous push and pop keep the occupancy
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> $stable(cnt));
endmodule

// File: rtl/cdq_sync_fsm.sv
module cdq_sync_fsm
    import cdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_accept,
    input  logic exc_hit,
    input  logic ack,
    input  logic q_empty,
    input  logic q_full,
    input  logic pop_fire,
    output logic stall,
    output logic exc_flag
);
    cdq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (exc_hit)         state_nx = ST_EXC;
                else if (sys_accept) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (exc_hit)      state_nx = ST_EXC;
                else if (q_empty) state_nx = ST_RUN;
            end
            ST_EXC: begin
                if (ack) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        stall    = 1'b0;
        exc_flag = 1'b0;
        unique case (state)
            ST_RUN:   stall = q_full && !pop_fire;
            ST_DRAIN: stall = 1'b1;
            ST_EXC: begin
                stall    = 1'b1;
                exc_flag = 1'b1;
            end
            default: stall = 1'b1;
        endcase
    end

    // R5: the barrier always holds the core
    p_drain_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> stall);
    // R5: an empty queue with no exception ends the barrier
    p_drain_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && q_empty && !exc_hit) |=> (state == ST_RUN));
    // R6: an exception pop outside the exception state is latched
    p_exc_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_hit && state != ST_EXC) |=> (state == ST_EXC));
    // R7: acknowledge leaves the exception state
    p_ack_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXC && ack) |=> (state == ST_RUN));
    // R8: without acknowledge the exception state persists
    p_exc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXC && !ack) |=> (state == ST_EXC));
endmodule

// File: rtl/cop_decouple_q.sv
module cop_decouple_q #(
    parameter int PC_W  = 32,
    parameter int ENC_W = 32,
    parameter int PA_W  = 36,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [ENC_W-1:0] push_enc,
    input  logic [PA_W-1:0]  push_paddr,
    input  logic             push_syscall,
    output logic             core_stall,
    output logic             core_exc,
    output logic             pop_valid,
    output logic [PC_W-1:0]  pop_pc,
    output logic [ENC_W-1:0] pop_enc,
    output logic [PA_W-1:0]  pop_paddr,
    output logic             pop_syscall,
    input  logic             cop_pop,
    input  logic             cop_exc,
    input  logic             exc_ack
);
    localparam int REC_W = PC_W + ENC_W + PA_W + 1;

    logic             q_empty, q_full;
    logic             push_fire, pop_fire;
    logic [REC_W-1:0] rec_in, rec_out;

    assign pop_fire  = cop_pop && !q_empty;
    assign push_fire = push_valid && !core_stall;
    assign rec_in    = {push_pc, push_enc, push_paddr, push_syscall};

    cdq_ring #(.W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_fire),
        .push_data(rec_in),
        .pop_en   (pop_fire),
        .head     (rec_out),
        .empty    (q_empty),
        .full     (q_full)
    );

    cdq_sync_fsm u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_accept(push_fire && push_syscall),
        .exc_hit   (pop_fire && cop_exc),
        .ack       (exc_ack),
        .q_empty   (q_empty),
        .q_full    (q_full),
        .pop_fire  (pop_fire),
        .stall     (core_stall),
        .exc_flag  (core_exc)
    );

    assign pop_valid = !q_empty;
    assign {pop_pc, pop_enc, pop_paddr, pop_syscall} = rec_out;

    // R7: nothing enters the queue while an exception is shown
    p_exc_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_exc |-> !push_fire);
endmodule

// File: tb/cop_decouple_q_bench.sv
module cop_decouple_q_bench;
    localparam int DEPTH = 5;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] enc;
        logic [35:0] pa;
        logic        sys;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, push_syscall = 1'b0;
    logic [31:0] push_pc = '0, push_enc = '0;
    logic [35:0] push_paddr = '0;
    logic cop_pop = 1'b0, cop_exc = 1'b0, exc_ack = 1'b0;
    logic core_stall, core_exc, pop_valid, pop_syscall;
    logic [31:0] pop_pc, pop_enc;
    logic [35:0] pop_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    rec_t exp_q[$];

    always #4 clk = ~clk;

    cop_decouple_q #(.PC_W(32), .ENC_W(32), .PA_W(36), .DEPTH(DEPTH)) u_cop_decouple_q (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_pc(push_pc), .push_enc(push_enc),
        .push_paddr(push_paddr), .push_syscall(push_syscall),
        .core_stall(core_stall), .core_exc(core_exc),
        .pop_valid(pop_valid), .pop_pc(pop_pc), .pop_enc(pop_enc),
        .pop_paddr(pop_paddr), .pop_syscall(pop_syscall),
        .cop_pop(cop_pop), .cop_exc(cop_exc), .exc_ack(exc_ack)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic rec_t mk(input int i, input bit s);
        rec_t r;
        r.pc  = 32'h1000_0000 + 32'(i * 4);
        r.enc = 32'hA5A5_0000 ^ 32'(i * 32'h0101_0303);
        r.pa  = 36'h8_0000_0000 | 36'(i * 36'h1_0040);
        r.sys = s;
        return r;
    endfunction

    // Monitor: a pop is consumed at the coming edge; compare with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cop_pop && pop_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 pop with empty scoreboard", 1, 0);
            end else begin
                rec_t e;
                rec_t a;
                e = exp_q.pop_front();
                a = '{pc: pop_pc, enc: pop_enc, pa: pop_paddr, sys: pop_syscall};
                chk(a == e, "R2 record order/content", a.pc, e.pc);
            end
        end
    end

    // Driver: one cycle of inputs; the record is scoreboarded if the block accepts it.
    task automatic drv(input bit pv, input rec_t r, input bit pp, input bit pe, input bit ak);
        @(posedge clk); #2;
        push_valid = pv; push_pc = r.pc; push_enc = r.enc; push_paddr = r.pa;
        push_syscall = r.sys; cop_pop = pp; cop_exc = pe; exc_ack = ak;
        @(negedge clk);
        if (pv && !core_stall) exp_q.push_back(r);
    endtask

    task automatic idle();
        drv(0, '0, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pop_valid == 0, "R1 pop_valid", pop_valid, 0);
        chk(core_stall == 0, "R1 core_stall", core_stall, 0);
        chk(core_exc == 0, "R1 core_exc", core_exc, 0);

        // R2 streaming order
        for (int i = 0; i < 3; i++) drv(1, mk(i, 0), 0, 0, 0);
        for (int i = 0; i < 3; i++) drv(0, '0, 1, 0, 0);
        idle();
        chk(pop_valid == 0, "R2 drained", pop_valid, 0);

        // R3 / R4 full boundary
        for (int i = 10; i < 10 + DEPTH; i++) begin
            drv(1, mk(i, 0), 0, 0, 0);
            chk(core_stall == 0, "R3 accept below full", core_stall, 0);
        end
        drv(1, mk(99, 0), 0, 0, 0);
        chk(core_stall == 1, "R3 stall when full", core_stall, 1);
        drv(1, mk(20, 0), 1, 0, 0);
        chk(core_stall == 0, "R4 push+pop when full", core_stall, 0);
        idle();
        chk(core_stall == 1, "R4 still full", core_stall, 1);
        for (int i = 0; i < DEPTH; i++) drv(0, '0, 1, 0, 0);
        idle();
        chk(pop_valid == 0, "R3 rejected push absent", pop_valid, 0);
        chk(core_stall == 0, "R3 stall released", core_stall, 0);

        // R5 system-call barrier
        drv(1, mk(30, 0), 0, 0, 0);
        drv(1, mk(31, 0), 0, 0, 0);
        drv(1, mk(32, 1), 0, 0, 0);
        chk(core_stall == 0, "R5 syscall accepted", core_stall, 0);
        idle();
        chk(core_stall == 1, "R5 stall after syscall", core_stall, 1);
        drv(1, mk(98, 0), 0, 0, 0);
        chk(core_stall == 1, "R5 push blocked in drain", core_stall, 1);
        for (int i = 0; i < 3; i++) begin
            drv(0, '0, 1, 0, 0);
            chk(core_stall == 1, "R5 stall while draining", core_stall, 1);
        end
        idle();
        chk(core_stall == 1, "R5 stall in empty cycle", core_stall, 1);
        idle();
        chk(core_stall == 0, "R5 release after drain", core_stall, 0);
        chk(pop_valid == 0, "R5 blocked push absent", pop_valid, 0);

        // R6 / R7 exception in streaming
        drv(1, mk(40, 0), 0, 0, 0);
        drv(1, mk(41, 0), 0, 0, 0);
        drv(0, '0, 1, 1, 0);
        chk(core_exc == 0, "R6 exc not yet", core_exc, 0);
        idle();
        chk(core_exc == 1, "R6 exc raised", core_exc, 1);
        chk(core_stall == 1, "R6 stall on exc", core_stall, 1);
        drv(1, mk(97, 0), 0, 0, 0);
        chk(core_stall == 1, "R7 push ignored in exc", core_stall, 1);
        drv(0, '0, 0, 0, 1);
        idle();
        chk(core_exc == 0, "R7 ack clears exc", core_exc, 0);
        chk(core_stall == 0, "R7 ack clears stall", core_stall, 0);
        drv(0, '0, 1, 0, 0);
        idle();
        chk(pop_valid == 0, "R7 ignored push absent", pop_valid, 0);

        // R8 exception during system-call drain
        drv(1, mk(50, 1), 0, 0, 0);
        idle();
        drv(0, '0, 1, 1, 0);
        idle();
        chk(core_exc == 1, "R8 exc in drain", core_exc, 1);
        chk(pop_valid == 0, "R8 queue drained", pop_valid, 0);
        idle();
        chk(core_stall == 1, "R8 stall held past drain", core_stall, 1);
        drv(0, '0, 0, 0, 1);
        idle();
        chk(core_stall == 0, "R8 ack releases", core_stall, 0);

        // R9 pop on empty
        drv(0, '0, 1, 1, 0);
        idle();
        chk(core_exc == 0, "R9 empty pop exc ignored", core_exc, 0);
        chk(pop_valid == 0, "R9 empty stays empty", pop_valid, 0);
        drv(1, mk(60, 0), 0, 0, 0);
        idle();
        chk(pop_valid == 1, "R9 single record present", pop_valid, 1);
        drv(0, '0, 1, 0, 0);
        idle();
        chk(pop_valid == 0, "R9 single record popped", pop_valid, 0);

        chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule